// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that gives a host three 24-bit registers over a handful of pins. The host can read a captured conversion result or a status word, and it can write a configuration word. The serial clock comes from the host and is not used as a clock inside the block. It is brought into the system clock domain through a two-stage synchronizer, together with the serial data input, and its edges are detected there. Data out carries an output-enable so the pad can be put into high impedance. A data-ready output tells the host that an unread result is waiting.

The configuration word reaches the rest of the chip through `cfg_o`, and its source depends on the mode:

- **Hardware mode:** the word follows a set of parallel pins.
- **Software mode:** the word holds whatever was last written serially.
- **Configuration reset:** while it is held, the register copies the pins on every cycle.

Because data-ready drops as soon as a data word has been shifted out, the host can wire data-ready to register select. One frame of 48 clocks then returns the result followed by the status word.

Top module: `serial_reg_port`

## Requirements
- R1: `sdo_en_o` is 1 only while `cs_ni` is 0 and `rd_wr_i` is 1 (1 = read, 0 = write); with `cs_ni` high or `rd_wr_i` low it is 0.
- R2: In a read, `reg_sel_i` = 1 returns the latest captured result and `reg_sel_i` = 0 returns `status_i`, MSB first, one bit per SCLK period. Each bit is stable at the SCLK falling edge and advances after the following rising edge. The word is taken at the first falling edge of each 24-bit group.
- R3: A one-cycle `result_valid_i` pulse captures `result_i` and sets `drdy_o` on the next clock. `drdy_o` clears after the 24th falling edge of a read that loaded the result word. A read of the status word leaves `drdy_o` unchanged.
- R4: With `reg_sel_i` driven by `drdy_o`, a 48-edge read frame returns the result word and then the status word, and leaves `drdy_o` low.
- R5: In a write frame (`cs_ni` = 0, `rd_wr_i` = 0), the 24 bits sampled at the falling edges, MSB first, are committed to the configuration register after the 24th edge. In software mode `cfg_o` then shows that word.
- R6: A write frame that ends (`cs_ni` high) before 24 falling edges leaves the configuration register unchanged.
- R7: With `hw_mode_i` = 1, `cfg_o` equals `cfg_pins_i`. The register keeps its value, which `cfg_o` shows again once `hw_mode_i` returns to 0.
- R8: While `cfg_rst_i` = 1, `cfg_o` equals `cfg_pins_i` and the register loads `cfg_pins_i` on every clock. After release, in software mode, `cfg_o` keeps that value.
- R9: After `rst_ni` is asserted, `drdy_o` is 0 and the configuration register is 0.
- R10: A result arriving in the same cycle that a result read completes keeps `drdy_o` at 1, and the new result becomes the next data word.
- R11: SCLK edges while `cs_ni` is high are ignored. The next frame still starts at the MSB, and the configuration is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| reg_sel_i | input | 1 | Read source: 1 = result, 0 = status |
| sclk_i | input | 1 | Serial clock from host, idles low |
| sdi_i | input | 1 | Serial write data |
| sdo_o | output | 1 | Serial read data |
| sdo_en_o | output | 1 | Output enable for the data-out pad |
| drdy_o | output | 1 | Unread result available |
| result_i | input | 24 | New conversion result |
| result_valid_i | input | 1 | One-cycle strobe for result_i |
| status_i | input | 24 | Live status word |
| hw_mode_i | input | 1 | 1 = configuration from pins |
| cfg_rst_i | input | 1 | Synchronous configuration reset |
| cfg_pins_i | input | 24 | Parallel configuration pins |
| cfg_o | output | 24 | Active configuration word |

## Verification
Reads are exercised with result and status words whose patterns differ in their MSB, their LSB and their interior bits. This separates a wrong source selection from an off-by-one shift and from a lost first or last bit. Writes use an asymmetric pattern, so that a bit-order reversal or a missed edge shows up in `cfg_o`. Further tests cover a truncated write, a long frame with data-ready tied to register select, and a result strobe placed exactly on the cycle a read completes. These separate the commit rule, the reload on word boundaries and the set-over-clear priority of data-ready.

// File: rtl/srp_pkg.sv
package srp_pkg;
  parameter int WORD_W    = 24;
  parameter int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
#(
  parameter int WORD_W = srp_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              sdo_o,
  output logic              load_o,
  output logic              rd_done_o,
  output logic              wr_done_o,
  output logic [WORD_W-1:0] wr_word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic              rise, fall, last;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  xfer_e             mode;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;
  assign last = (cnt_q == LAST);

  always_comb begin
    if (cs_ni)        mode = XF_IDLE;
    else if (rd_wr_i) mode = XF_READ;
    else              mode = XF_WRITE;
  end

  assign load_o    = (mode == XF_READ)  && fall && (cnt_q == '0);
  assign rd_done_o = (mode == XF_READ)  && fall && last;
  assign wr_done_o = (mode == XF_WRITE) && fall && last;
  assign wr_word_o = {rx_q[WORD_W-2:0], sdi_s_i};

  // bit counter wraps per word so long frames reload on each boundary
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cnt_q <= '0;
    else if (cs_ni)    cnt_q <= '0;
    else if (fall)     cnt_q <= last ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      tx_q <= '0;
    else if (load_o)  tx_q <= tx_word_i;
    else if ((mode == XF_READ) && rise && (cnt_q != '0))
                      tx_q <= {tx_q[WORD_W-2:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          rx_q <= '0;
    else if ((mode == XF_WRITE) && fall)  rx_q <= wr_word_o;

  // before the first edge of a word the source MSB is presented directly
  assign sdo_o = (cnt_q == '0) ? tx_word_i[WORD_W-1] : tx_q[WORD_W-1];

  a_r11_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r11_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cnt_q == '0));
  a_r2_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise && !load_o) |=> $stable(tx_q));
endmodule

// File: rtl/srp_cfg_reg.sv
module srp_cfg_reg #(
  parameter int WORD_W = srp_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_mode_i,
  input  logic              cfg_rst_i,
  input  logic [WORD_W-1:0] pins_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_word_i,
  output logic [WORD_W-1:0] cfg_o
);
  logic [WORD_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        cfg_q <= '0;
    else if (cfg_rst_i) cfg_q <= pins_i;
    else if (wr_en_i)   cfg_q <= wr_word_i;

  assign cfg_o = (hw_mode_i || cfg_rst_i) ? pins_i : cfg_q;

  a_r8_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_i |=> (cfg_q == $past(pins_i)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rst_i && !wr_en_i) |=> $stable(cfg_q));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int WORD_W     = srp_pkg::WORD_W,
  parameter int SYNC_DEPTH = srp_pkg::SYNC_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic              reg_sel_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              drdy_o,
  input  logic [WORD_W-1:0] result_i,
  input  logic              result_valid_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic              hw_mode_i,
  input  logic              cfg_rst_i,
  input  logic [WORD_W-1:0] cfg_pins_i,
  output logic [WORD_W-1:0] cfg_o
);
  logic [1:0]        pin_s;
  logic              sh_sdo, load, rd_done, wr_done;
  logic [WORD_W-1:0] wr_word, tx_word, data_q;
  logic              src_data_q, drdy_q;

  srp_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdi_i}),
    .q_o   (pin_s)
  );

  assign tx_word = reg_sel_i ? data_q : status_i;

  srp_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .rd_wr_i  (rd_wr_i),
    .sclk_s_i (pin_s[1]),
    .sdi_s_i  (pin_s[0]),
    .tx_word_i(tx_word),
    .sdo_o    (sh_sdo),
    .load_o   (load),
    .rd_done_o(rd_done),
    .wr_done_o(wr_done),
    .wr_word_o(wr_word)
  );

  srp_cfg_reg #(.WORD_W(WORD_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_mode_i(hw_mode_i),
    .cfg_rst_i(cfg_rst_i),
    .pins_i   (cfg_pins_i),
    .wr_en_i  (wr_done),
    .wr_word_i(wr_word),
    .cfg_o    (cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     src_data_q <= 1'b0;
    else if (load)   src_data_q <= reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             data_q <= '0;
    else if (result_valid_i) data_q <= result_i;

  // a new result wins over the clear from a finished read
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     drdy_q <= 1'b0;
    else if (result_valid_i)         drdy_q <= 1'b1;
    else if (rd_done && src_data_q)  drdy_q <= 1'b0;

  assign drdy_o   = drdy_q;
  assign sdo_en_o = ~cs_ni & rd_wr_i;
  assign sdo_o    = sdo_en_o & sh_sdo;

  a_r3_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_q) |-> $past(result_valid_i));
  a_r3_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_q) |-> $past(rd_done && src_data_q));
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_i |=> drdy_q);
  a_r5_no_write_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wr_i |-> !wr_done);
endmodule

// File: tb/serial_reg_port_bench.sv
module serial_reg_port_bench;
  localparam int W = 24;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_wr = 1'b1, sel_drv = 1'b1, tie = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] result = '0, status = '0, pins = '0;
  logic rvalid = 1'b0, hw_mode = 1'b0, cfg_rst = 1'b0;
  logic sdo, sdo_en, drdy, reg_sel;
  logic [W-1:0] cfg;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign reg_sel = tie ? drdy : sel_drv;

  serial_reg_port u_serial_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_wr_i(rd_wr),
    .reg_sel_i(reg_sel), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .sdo_en_o(sdo_en), .drdy_o(drdy), .result_i(result),
    .result_valid_i(rvalid), .status_i(status), .hw_mode_i(hw_mode),
    .cfg_rst_i(cfg_rst), .cfg_pins_i(pins), .cfg_o(cfg)
  );

  // {result, status, reg_sel}
  localparam logic [48:0] VEC [6] = '{
    {24'h800001, 24'h7FFFFE, 1'b1},
    {24'h800001, 24'h7FFFFE, 1'b0},
    {24'hA5C3E1, 24'h0F0F0F, 1'b1},
    {24'h123456, 24'hFEDCBA, 1'b0},
    {24'h000000, 24'hFFFFFF, 1'b1},
    {24'hFFFFFF, 24'h000000, 1'b0}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_result(input logic [W-1:0] v);
    result = v; rvalid = 1'b1;
    wait_n(1);
    rvalid = 1'b0;
    wait_n(2);
  endtask

  task automatic do_read(input int nbits, input bit inject, input logic [W-1:0] inj,
                         output logic [47:0] got);
    got = '0;
    rd_wr = 1'b1; cs_n = 1'b0;
    wait_n(4);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1'b1;
      wait_n(H);
      got = {got[46:0], sdo};
      sclk = 1'b0;
      if (inject && k == nbits - 1) begin
        wait_n(2);
        result = inj; rvalid = 1'b1;
        wait_n(1);
        rvalid = 1'b0;
        wait_n(H - 3);
      end else begin
        wait_n(H);
      end
    end
    wait_n(2);
    cs_n = 1'b1;
    wait_n(4);
  endtask

  task automatic do_write(input int nbits, input logic [W-1:0] word);
    rd_wr = 1'b0; cs_n = 1'b0;
    wait_n(4);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1'b1; sdi = word[W-1-k];
      wait_n(H);
      sclk = 1'b0;
      wait_n(H);
    end
    wait_n(3);
    cs_n = 1'b1; rd_wr = 1'b1;
    wait_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] got;
    wait_n(3);
    // R9 reset state
    check("R9 drdy", W'(drdy), W'(1'b0));
    check("R9 cfg", cfg, '0);
    rst_n = 1'b1;
    wait_n(2);
    check("R9 drdy after release", W'(drdy), W'(1'b0));
    // R1 output enable
    check("R1 cs high", W'(sdo_en), W'(1'b0));
    cs_n = 1'b0; rd_wr = 1'b0; wait_n(1);
    check("R1 write dir", W'(sdo_en), W'(1'b0));
    rd_wr = 1'b1; wait_n(1);
    check("R1 read dir", W'(sdo_en), W'(1'b1));
    cs_n = 1'b1; wait_n(4);

    // R2/R3 table walk
    for (int i = 0; i < 6; i++) begin
      status = VEC[i][24:1];
      sel_drv = VEC[i][0];
      pulse_result(VEC[i][48:25]);
      check("R3 drdy set", W'(drdy), W'(1'b1));
      do_read(W, 1'b0, '0, got);
      check("R2 read word", got[W-1:0], VEC[i][0] ? VEC[i][48:25] : VEC[i][24:1]);
      check("R3 drdy after read", W'(drdy), W'(!VEC[i][0]));
    end

    // R4 chained read
    status = 24'h3C5A96;
    pulse_result(24'hC1E2F3);
    tie = 1'b1;
    do_read(2 * W, 1'b0, '0, got);
    tie = 1'b0;
    check("R4 first word", got[47:24], 24'hC1E2F3);
    check("R4 second word", got[23:0], 24'h3C5A96);
    check("R4 drdy low", W'(drdy), W'(1'b0));

    // R10 set wins over clear
    sel_drv = 1'b1;
    pulse_result(24'h0BADF0);
    do_read(W, 1'b1, 24'h5EED11, got);
    check("R10 word", got[W-1:0], 24'h0BADF0);
    check("R10 drdy kept", W'(drdy), W'(1'b1));
    do_read(W, 1'b0, '0, got);
    check("R10 next word", got[W-1:0], 24'h5EED11);

    // R5 write
    do_write(W, 24'hB4C2E9);
    check("R5 cfg", cfg, 24'hB4C2E9);
    // R6 partial write
    do_write(10, 24'h123456);
    check("R6 partial", cfg, 24'hB4C2E9);
    // R7 hardware mode
    pins = 24'h6D1A77; hw_mode = 1'b1; wait_n(1);
    check("R7 hw pins", cfg, 24'h6D1A77);
    hw_mode = 1'b0; wait_n(1);
    check("R7 back to sw", cfg, 24'hB4C2E9);
    // R8 config reset
    pins = 24'h0FACE5; cfg_rst = 1'b1; wait_n(1);
    check("R8 during", cfg, 24'h0FACE5);
    wait_n(2); cfg_rst = 1'b0; pins = 24'h111111; wait_n(1);
    check("R8 after", cfg, 24'h0FACE5);

    // R11 sclk with cs high ignored
    pulse_result(24'h9E3779);
    sel_drv = 1'b1; rd_wr = 1'b0;
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; sdi = k[0]; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    rd_wr = 1'b1;
    check("R11 cfg unchanged", cfg, 24'h0FACE5);
    do_read(W, 1'b0, '0, got);
    check("R11 word from msb", got[W-1:0], 24'h9E3779);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule